// File: doc/BRIEF.md
# Per-Input Trigger-Mode Interrupt Controller

This block collects 32 interrupt lines and turns them into two request outputs and one wake output. Each line carries its own trigger mode, chosen from rising edge, falling edge, either edge, high level and low level. The mode is a 3-bit code whose bits live in three separate configuration words. Edge events are latched in a rising-capture word and a falling-capture word. A latched event stays there until software clears it by writing ones to a clear address. Level modes follow the synchronized input directly.

Software reaches every control word through a simple synchronous bus. Each word has a read address, a write-one-to-set address and a write-one-to-clear address, so single bits can be changed without a read-modify-write. A per-line enable gates a line onto the request outputs. A per-line route bit picks which of the two request outputs it drives. A separate per-line wake enable feeds the wake output. Each request output also has a readable pending word. Inputs 32 to 63 are served by placing a second instance beside the first.

Top module: `irq_trigger_ctrl`

Address layout: `addr[5:2]` selects a word slot and `addr[1:0]` selects the operation (0 read, 1 set, 2 clear, 3 load). The slots are:

| Slot | Word |
|------|------|
| 0 | mode bit 0 |
| 1 | mode bit 1 |
| 2 | mode bit 2 |
| 3 | source |
| 4 | route |
| 5 | wake enable |
| 6 | line enable |
| 7 | rising capture |
| 8 | falling capture |
| 9 | pending on request 0 |
| 10 | pending on request 1 |
| 11 | test |

## Requirements
- R1: After reset, the mode, line-enable, wake-enable, capture and test words read 0. The source and route words read all ones. Both request outputs are low.
- R2: For slots 0 to 6, a write to the set address (op 1) ORs `bus_wdata` into the word. A write to the clear address (op 2) clears the bits where `bus_wdata` is 1. Zero bits leave the word unchanged. The new value reads back at op 0 from the next cycle.
- R3: Mode code 001 (value {slot2[n], slot1[n], slot0[n]}) sets rising-capture bit n on a rising edge of the synchronized input. Writing 1 to that bit at the rising-capture clear address (0x1E) clears it. A new edge in the same cycle as the clear wins.
- R4: Code 010 sets the falling-capture bit on a falling edge, and the clear address for that word is 0x22. Code 011 captures both edges. In these modes a line is active while any of its enabled capture bits is set.
- R5: Code 101 makes a line active while its synchronized input is high. Code 110 makes it active while the input is low. Level modes never set capture bits.
- R6: Codes 000, 100 and 111 never set a capture bit and never make a line active.
- R7: A line reaches a request output only while its line-enable bit (slot 6) is 1. Writing all ones to the line-enable clear address (0x1A) forces both request outputs low from the next cycle.
- R8: An active, enabled line with route bit 1 appears in pending word 0 (0x24) and drives `req0_o`. With route bit 0 it appears in pending word 1 (0x28) and drives `req1_o`. Each request output is the OR of its pending word.
- R9: `wake_o` is high while any active line has its wake-enable bit set, whatever its line-enable bit.
- R10: A write at the test load address (0x2F) stores `bus_wdata` in the test word, and 0x2C reads it back. Loading zero clears it.
- R11: Level modes reach a request output on the second rising clock edge after the input changes. Edge modes reach it on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw interrupt lines |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 6 | Word slot and operation |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data for op 0 at `bus_addr`, otherwise 0 |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake output |

## Verification
The hardest case to reach from the ports is a capture-clear write that lands on the same clock edge where a new edge is latched. The bench drives the input edge and then counts the two synchronizer stages. It puts the clear write on the bus so that it is sampled on the capture edge, then reads the capture word to confirm the new event survived. The bench also programs all eight codes, including the two undefined ones, onto neighbouring lines at once. Toggling all of those lines together exercises every mode, both routes, the enable gate and the wake gate in a single stimulus pattern. A reference model checks the outputs on every cycle.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

    localparam int ADDR_W   = 6;
    localparam int SLOT_W   = ADDR_W - 2;
    localparam int NUM_BANK = 7;

    typedef enum logic [2:0] {
        TRIG_OFF  = 3'b000,
        TRIG_RISE = 3'b001,
        TRIG_FALL = 3'b010,
        TRIG_BOTH = 3'b011,
        TRIG_HIGH = 3'b101,
        TRIG_LOW  = 3'b110
    } trig_mode_e;

    localparam logic [SLOT_W-1:0] SLOT_CFG0  = 4'd0;
    localparam logic [SLOT_W-1:0] SLOT_CFG1  = 4'd1;
    localparam logic [SLOT_W-1:0] SLOT_CFG2  = 4'd2;
    localparam logic [SLOT_W-1:0] SLOT_SRC   = 4'd3;
    localparam logic [SLOT_W-1:0] SLOT_ROUTE = 4'd4;
    localparam logic [SLOT_W-1:0] SLOT_WAKE  = 4'd5;
    localparam logic [SLOT_W-1:0] SLOT_EN    = 4'd6;
    localparam logic [SLOT_W-1:0] SLOT_RCAP  = 4'd7;
    localparam logic [SLOT_W-1:0] SLOT_FCAP  = 4'd8;
    localparam logic [SLOT_W-1:0] SLOT_PEND0 = 4'd9;
    localparam logic [SLOT_W-1:0] SLOT_PEND1 = 4'd10;
    localparam logic [SLOT_W-1:0] SLOT_TEST  = 4'd11;

    localparam logic [1:0] OP_READ = 2'd0;
    localparam logic [1:0] OP_SET  = 2'd1;
    localparam logic [1:0] OP_CLR  = 2'd2;
    localparam logic [1:0] OP_LOAD = 2'd3;

    function automatic logic [ADDR_W-1:0] word_addr(logic [SLOT_W-1:0] slot, logic [1:0] op);
        return {slot, op};
    endfunction

endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_trig_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [N-1:0]                   wdata,
    output logic [NUM_BANK-1:0][N-1:0]     bank_o,
    output logic [N-1:0]                   test_o
);

    logic [SLOT_W-1:0] slot;
    logic [1:0]        op;

    assign slot = addr[ADDR_W-1:2];
    assign op   = addr[1:0];

    // Set/clear words; source and route come out of reset as all ones
    for (genvar k = 0; k < NUM_BANK; k++) begin : g_bank
        localparam bit ONES_AT_RST = (k == int'(SLOT_SRC)) || (k == int'(SLOT_ROUTE));
        logic [N-1:0] word_q;
        logic         hit;

        assign hit = we && (slot == SLOT_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= ONES_AT_RST ? {N{1'b1}} : {N{1'b0}};
            end else if (hit) begin
                if (op == OP_SET) begin
                    word_q <= word_q | wdata;
                end else if (op == OP_CLR) begin
                    word_q <= word_q & ~wdata;
                end
            end
        end

        assign bank_o[k] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_o <= '0;
        end else if (we && slot == SLOT_TEST && op == OP_LOAD) begin
            test_o <= wdata;
        end
    end

endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rose_o,
    output logic [N-1:0] fell_o
);

    // STAGES synchronizer flops plus one history flop for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][N-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= raw_in;
            for (int s = 1; s < DEPTH; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign lvl_o  = pipe_q[STAGES-1];
    assign rose_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fell_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/irq_trig_eval.sv
module irq_trig_eval
    import irq_trig_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] mode0,
    input  logic [N-1:0] mode1,
    input  logic [N-1:0] mode2,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] rose,
    input  logic [N-1:0] fell,
    input  logic [N-1:0] rclr,
    input  logic [N-1:0] fclr,
    output logic [N-1:0] rcap_o,
    output logic [N-1:0] fcap_o,
    output logic [N-1:0] active_o
);

    for (genvar i = 0; i < N; i++) begin : g_line
        trig_mode_e md;
        logic       rise_en;
        logic       fall_en;
        logic       lvl_act;
        logic       rc_q;
        logic       fc_q;

        assign md = trig_mode_e'({mode2[i], mode1[i], mode0[i]});

        // Undefined codes fall into the default arm: no capture, never active
        always_comb begin
            rise_en = 1'b0;
            fall_en = 1'b0;
            lvl_act = 1'b0;
            case (md)
                TRIG_RISE: rise_en = 1'b1;
                TRIG_FALL: fall_en = 1'b1;
                TRIG_BOTH: begin
                    rise_en = 1'b1;
                    fall_en = 1'b1;
                end
                TRIG_HIGH: lvl_act = lvl[i];
                TRIG_LOW:  lvl_act = ~lvl[i];
                default:   lvl_act = 1'b0;
            endcase
        end

        // A fresh edge outranks a clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rc_q <= 1'b0;
                fc_q <= 1'b0;
            end else begin
                rc_q <= (rose[i] & rise_en) | (rc_q & ~rclr[i]);
                fc_q <= (fell[i] & fall_en) | (fc_q & ~fclr[i]);
            end
        end

        assign rcap_o[i]   = rc_q;
        assign fcap_o[i]   = fc_q;
        assign active_o[i] = lvl_act | (rise_en & rc_q) | (fall_en & fc_q);
    end

endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl
    import irq_trig_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);

    logic [NUM_BANK-1:0][N-1:0] bank;
    logic [N-1:0] test_q;
    logic [N-1:0] cfg0_q, cfg1_q, cfg2_q, src_q, route_q, wake_q, en_q;
    logic [N-1:0] lvl, rose, fell;
    logic [N-1:0] rclr, fclr;
    logic [N-1:0] rcap, fcap, active;
    logic [N-1:0] pend0, pend1;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        op;

    assign slot = bus_addr[ADDR_W-1:2];
    assign op   = bus_addr[1:0];

    irq_ctl_regs #(.N(N)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .bank_o (bank),
        .test_o (test_q)
    );

    assign cfg0_q  = bank[SLOT_CFG0];
    assign cfg1_q  = bank[SLOT_CFG1];
    assign cfg2_q  = bank[SLOT_CFG2];
    assign src_q   = bank[SLOT_SRC];
    assign route_q = bank[SLOT_ROUTE];
    assign wake_q  = bank[SLOT_WAKE];
    assign en_q    = bank[SLOT_EN];

    irq_edge_sync #(.N(N), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (irq_in),
        .lvl_o  (lvl),
        .rose_o (rose),
        .fell_o (fell)
    );

    assign rclr = (bus_we && slot == SLOT_RCAP && op == OP_CLR) ? bus_wdata : '0;
    assign fclr = (bus_we && slot == SLOT_FCAP && op == OP_CLR) ? bus_wdata : '0;

    irq_trig_eval #(.N(N)) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode0    (cfg0_q),
        .mode1    (cfg1_q),
        .mode2    (cfg2_q),
        .lvl      (lvl),
        .rose     (rose),
        .fell     (fell),
        .rclr     (rclr),
        .fclr     (fclr),
        .rcap_o   (rcap),
        .fcap_o   (fcap),
        .active_o (active)
    );

    assign pend0  = active & en_q & route_q;
    assign pend1  = active & en_q & ~route_q;
    assign req0_o = |pend0;
    assign req1_o = |pend1;
    assign wake_o = |(active & wake_q);

    always_comb begin
        bus_rdata = '0;
        if (op == OP_READ) begin
            case (slot)
                SLOT_CFG0:  bus_rdata = cfg0_q;
                SLOT_CFG1:  bus_rdata = cfg1_q;
                SLOT_CFG2:  bus_rdata = cfg2_q;
                SLOT_SRC:   bus_rdata = src_q;
                SLOT_ROUTE: bus_rdata = route_q;
                SLOT_WAKE:  bus_rdata = wake_q;
                SLOT_EN:    bus_rdata = en_q;
                SLOT_RCAP:  bus_rdata = rcap;
                SLOT_FCAP:  bus_rdata = fcap;
                SLOT_PEND0: bus_rdata = pend0;
                SLOT_PEND1: bus_rdata = pend1;
                SLOT_TEST:  bus_rdata = test_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_trigger_ctrl_chk.sv
module irq_trigger_ctrl_chk
    import irq_trig_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      en,
    input logic [N-1:0]      route,
    input logic [N-1:0]      wake,
    input logic [N-1:0]      cfg0,
    input logic [N-1:0]      cfg1,
    input logic [N-1:0]      cfg2,
    input logic [N-1:0]      rcap,
    input logic [N-1:0]      fcap,
    input logic              req0,
    input logic              req1,
    input logic              wk
);

    logic [N-1:0] rise_ok, fall_ok;
    assign rise_ok = cfg0 & ~cfg1 & ~cfg2 | cfg0 & cfg1 & ~cfg2;
    assign fall_ok = cfg1 & ~cfg0 & ~cfg2 | cfg0 & cfg1 & ~cfg2;

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == word_addr(SLOT_EN, OP_SET)) |=> ((en & $past(bus_wdata)) == $past(bus_wdata)));

    assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == word_addr(SLOT_EN, OP_CLR)) |=> ((en & $past(bus_wdata)) == '0));

    assert_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == word_addr(SLOT_EN, OP_CLR) && bus_wdata == {N{1'b1}}) |=> (!req0 && !req1));

    assert_rise_mode_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rcap & ~$past(rcap) & ~$past(rise_ok)) == '0));

    assert_fall_mode_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fcap & ~$past(fcap) & ~$past(fall_ok)) == '0));

    assert_route0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req0 |-> (|(en & route)));

    assert_route1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req1 |-> (|(en & ~route)));

    assert_wake_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake == '0) |-> !wk);

endmodule

bind irq_trigger_ctrl irq_trigger_ctrl_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en        (en_q),
    .route     (route_q),
    .wake      (wake_q),
    .cfg0      (cfg0_q),
    .cfg1      (cfg1_q),
    .cfg2      (cfg2_q),
    .rcap      (rcap),
    .fcap      (fcap),
    .req0      (req0_o),
    .req1      (req1_o),
    .wk        (wake_o)
);

// File: tb/irq_trigger_ctrl_tb.sv
module irq_trigger_ctrl_tb;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_we = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic          req0_o, req1_o, wake_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_trigger_ctrl #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
    );

    // Behavioural reference model: word index 0..6 = mode0, mode1, mode2, source, route, wake, enable
    logic [N-1:0] m_word [7];
    logic [N-1:0] m_test, m_rc, m_fc;
    logic [N-1:0] m_hist [$];

    function automatic int m_code(int n);
        return {m_word[2][n], m_word[1][n], m_word[0][n]};
    endfunction

    function automatic logic [N-1:0] m_level();
        return (m_hist.size() >= 2) ? m_hist[1] : '0;
    endfunction

    function automatic logic [N-1:0] m_active();
        logic [N-1:0] a;
        logic [N-1:0] lv;
        lv = m_level();
        a = '0;
        for (int n = 0; n < N; n++) begin
            case (m_code(n))
                1: a[n] = m_rc[n];
                2: a[n] = m_fc[n];
                3: a[n] = m_rc[n] | m_fc[n];
                5: a[n] = lv[n];
                6: a[n] = ~lv[n];
                default: a[n] = 1'b0;
            endcase
        end
        return a;
    endfunction

    function automatic logic [N-1:0] m_read(logic [5:0] a);
        int slot;
        slot = int'(a[5:2]);
        if (a[1:0] != 2'd0) return '0;
        if (slot < 7) return m_word[slot];
        case (slot)
            7: return m_rc;
            8: return m_fc;
            9: return m_active() & m_word[6] & m_word[4];
            10: return m_active() & m_word[6] & ~m_word[4];
            11: return m_test;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 7; k++) m_word[k] = (k == 3 || k == 4) ? '1 : '0;
            m_test = '0; m_rc = '0; m_fc = '0;
            m_hist = {};
            m_hist.push_front('0); m_hist.push_front('0); m_hist.push_front('0);
        end else begin
            logic [N-1:0] now_v, old_v;
            now_v = m_hist[1];
            old_v = m_hist[2];
            for (int n = 0; n < N; n++) begin
                bit re, fe;
                re = (m_code(n) == 1) || (m_code(n) == 3);
                fe = (m_code(n) == 2) || (m_code(n) == 3);
                if (re && now_v[n] && !old_v[n]) m_rc[n] = 1'b1;
                else if (bus_we && bus_addr == 6'h1E && bus_wdata[n]) m_rc[n] = 1'b0;
                if (fe && !now_v[n] && old_v[n]) m_fc[n] = 1'b1;
                else if (bus_we && bus_addr == 6'h22 && bus_wdata[n]) m_fc[n] = 1'b0;
            end
            if (bus_we) begin
                for (int k = 0; k < 7; k++) begin
                    if (bus_addr == 6'(k * 4 + 1)) m_word[k] = m_word[k] | bus_wdata;
                    if (bus_addr == 6'(k * 4 + 2)) m_word[k] = m_word[k] & ~bus_wdata;
                end
                if (bus_addr == 6'h2F) m_test = bus_wdata;
            end
            m_hist.push_front(irq_in);
            void'(m_hist.pop_back());
        end
    end

    // Every-cycle comparison of the outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] a;
            logic e0, e1, ew;
            a  = m_active();
            e0 = |(a & m_word[6] & m_word[4]);
            e1 = |(a & m_word[6] & ~m_word[4]);
            ew = |(a & m_word[5]);
            checks++;
            if ({req0_o, req1_o, wake_o} !== {e0, e1, ew}) begin
                errors++;
                $display("FAIL R8/R9 per-cycle outputs: req0,req1,wake got %b%b%b expected %b%b%b at %0t",
                         req0_o, req1_o, wake_o, e0, e1, ew, $time);
            end
        end
    end

    task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [N-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(string tag, logic [5:0] a, logic [N-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic rd_model(string tag, logic [5:0] a);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, m_read(a));
    endtask

    task automatic prog(int n, logic [2:0] code);
        for (int k = 0; k < 3; k++) begin
            wr(6'(k * 4 + (code[k] ? 1 : 2)), 32'(1) << n);
        end
    endtask

    task automatic wait_cyc(int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset values
        rd("R1 mode0", 6'h00, '0);
        rd("R1 mode2", 6'h08, '0);
        rd("R1 source", 6'h0C, '1);
        rd("R1 route", 6'h10, '1);
        rd("R1 enable", 6'h18, '0);
        rd("R1 wake", 6'h14, '0);
        rd("R1 rcap", 6'h1C, '0);
        rd("R1 test", 6'h2C, '0);
        chk("R1 requests", {30'd0, req0_o, req1_o}, '0);

        // R2 set/clear semantics
        wr(6'h05, 32'hA5A5_0F0F);
        wr(6'h05, 32'h0000_00F0);
        rd("R2 set ORs", 6'h04, 32'hA5A5_0FFF);
        wr(6'h06, 32'h0000_0F00);
        rd("R2 clear", 6'h04, 32'hA5A5_00FF);
        wr(6'h06, 32'h0);
        rd("R2 zero clear no effect", 6'h04, 32'hA5A5_00FF);
        wr(6'h0D, 32'h0);
        rd("R2 zero set no effect on source", 6'h0C, '1);
        wr(6'h06, '1);
        rd("R2 clear all", 6'h04, '0);

        // R10 test word
        wr(6'h2F, 32'hDEAD_BEEF);
        rd("R10 load", 6'h2C, 32'hDEAD_BEEF);
        wr(6'h2F, 32'h0);
        rd("R10 load zero", 6'h2C, '0);

        // Program eight lines with every code
        prog(0, 3'b001);
        prog(1, 3'b010);
        prog(2, 3'b011);
        prog(3, 3'b101);
        prog(4, 3'b110);
        prog(5, 3'b000);
        prog(6, 3'b100);
        prog(7, 3'b111);
        wr(6'h12, 32'h0000_00F0);
        wr(6'h15, 32'h0000_0008);
        wr(6'h19, 32'h0000_00FF);
        wr(6'h1E, '1);
        wr(6'h22, '1);
        wait_cyc(3);

        irq_in = 32'h0000_00FF;
        wait_cyc(5);
        rd("R3 R4 R6 rising capture", 6'h1C, 32'h0000_0005);
        rd("R5 R6 falling capture still clear", 6'h20, 32'h0);
        rd_model("R8 pending0", 6'h24);
        rd_model("R8 pending1", 6'h28);
        irq_in = 32'h0;
        wait_cyc(5);
        rd("R4 R6 falling capture", 6'h20, 32'h0000_0006);
        rd("R3 rising capture held", 6'h1C, 32'h0000_0005);
        wr(6'h1E, 32'h1);
        rd("R3 clear one bit", 6'h1C, 32'h0000_0004);
        wr(6'h22, '1);
        rd("R4 clear falling", 6'h20, '0);

        // R7 global disable
        wr(6'h1A, '1);
        chk("R7 all off", {30'd0, req0_o, req1_o}, '0);

        // R9 wake ignores enable
        irq_in = 32'h0000_0008;
        wait_cyc(3);
        chk("R9 wake while disabled", {31'd0, wake_o}, 32'd1);
        chk("R9 no request", {31'd0, req0_o}, 32'd0);
        irq_in = 32'h0;
        wait_cyc(3);
        chk("R9 wake drops", {31'd0, wake_o}, 32'd0);

        // R8 routing of low-level line 4
        wr(6'h19, 32'h0000_0010);
        chk("R8 route0 bit0 -> req1", {30'd0, req0_o, req1_o}, 32'd1);
        wr(6'h11, 32'h0000_0010);
        chk("R8 route1 -> req0", {30'd0, req0_o, req1_o}, 32'd2);
        wr(6'h1A, '1);

        // R6 undefined and disabled codes stay silent
        wr(6'h19, 32'h0000_00E0);
        irq_in = 32'h0000_00E0;
        wait_cyc(4);
        chk("R6 no request high", {30'd0, req0_o, req1_o}, '0);
        irq_in = 32'h0;
        wait_cyc(4);
        chk("R6 no request low", {30'd0, req0_o, req1_o}, '0);
        rd("R6 no capture", 6'h1C, 32'h0000_0004);
        wr(6'h1A, '1);

        // R11 level latency: line 3 high mode, route 1
        wr(6'h19, 32'h0000_0008);
        @(negedge clk); irq_in = 32'h0000_0008;
        @(negedge clk); chk("R11 level after 1 edge", {31'd0, req0_o}, 32'd0);
        @(negedge clk); chk("R11 level after 2 edges", {31'd0, req0_o}, 32'd1);
        irq_in = 32'h0;
        wait_cyc(3);
        wr(6'h1A, '1);
        wr(6'h1E, '1);

        // R11 edge latency: line 0 rising mode
        wr(6'h19, 32'h0000_0001);
        @(negedge clk); irq_in = 32'h0000_0001;
        @(negedge clk); chk("R11 edge after 1 edge", {31'd0, req0_o}, 32'd0);
        @(negedge clk); chk("R11 edge after 2 edges", {31'd0, req0_o}, 32'd0);
        @(negedge clk); chk("R11 edge after 3 edges", {31'd0, req0_o}, 32'd1);

        // R3 new edge wins over a same-cycle clear
        irq_in = 32'h0;
        wait_cyc(4);
        wr(6'h1E, 32'h1);
        rd("R3 cleared before race", 6'h1C & 6'h3F, m_read(6'h1C));
        @(negedge clk); irq_in = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'h1E; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        bus_addr = 6'h1C;
        #0.5;
        chk("R3 edge wins over clear", bus_rdata & 32'h1, 32'h1);
        wr(6'h1E, 32'h1);
        rd("R3 plain clear", 6'h1C, m_read(6'h1C));
        chk("R3 bit0 cleared", bus_rdata & 32'h1, 32'h0);

        wait_cyc(2);
        finish_run();
    end

endmodule